// File: doc/BRIEF.md
# Two-Wire Slave Front End with Write-Busy Acknowledge Polling

This block is the receive side of a two-wire serial slave for a small device built around registers. It samples the clock and data lines through two-flop synchronisers and finds start and stop conditions. It then shifts in an identification byte and checks it against a fixed device type and two strapped address pins. If the byte matches, it acknowledges and shifts in an instruction byte. The block splits that byte into an opcode and a register pointer and presents them with a one-cycle strobe.

Some write opcodes count as nonvolatile. When the stop that closes such a write command arrives, an internal busy counter starts. While it runs, the block does not acknowledge its own identification byte. The master can therefore poll by sending a start and the identification byte repeatedly. The first acknowledge it receives shows that the internal write has completed. Data bytes after the instruction byte are handled elsewhere and are not acknowledged here.

Top module: `twowire_poll_slave`

## Requirements
- R1: After reset `sda_oe`, `cmd_stb` and `busy_o` are 0. A start (SDA falling while SCL is high) begins a new identification byte.
- R2: The identification byte is received MSB first. The device acknowledges it only when bits [7:4] equal 4'b0101 and bits [3:2] equal `addr_pins[1:0]`. Bit 1 is ignored, and bit 0 is the direction (0 = write, 1 = read).
- R3: An acknowledge drives `sda_oe` high from the SCL falling edge after the 8th data bit to the SCL falling edge that ends the 9th clock. `sda_oe` is 0 at all other times.
- R4: A mismatched identification byte gets no acknowledge. The rest of that transfer is ignored: there is no acknowledge on later bytes and no `cmd_stb`.
- R5: After a matched identification byte, the instruction byte is always acknowledged. Its opcode is bits [7:5] and its register pointer is bits [1:0]. When that acknowledge ends, `cmd_stb` pulses for one cycle with `opcode_o`, `ptr_o` and `rw_o` valid.
- R6: The busy timer starts when a stop (SDA rising while SCL is high) closes a write command whose opcode has its bit set in `NV_OPCODES`. `busy_o` then stays high for exactly `BUSY_CYCLES` clock cycles. It does not rise before that stop.
- R7: While `busy_o` is high, a matching identification byte gets no acknowledge. After the timer expires, the same byte is acknowledged again.
- R8: A start or stop in the middle of a byte aborts the transfer and clears the bit count. A repeated start then receives a fresh identification byte.
- R9: A stop after a read-direction command, or after a write whose opcode is not nonvolatile, does not start the busy timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| addr_pins | input | 2 | Strapped device address |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| cmd_stb | output | 1 | One-cycle pulse: instruction accepted |
| opcode_o | output | 3 | Decoded opcode |
| ptr_o | output | 2 | Register pointer |
| rw_o | output | 1 | Direction of the accepted command |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A change on a line takes effect at the third clock edge: two synchroniser flops come first, and the edge register that detects it follows. The acknowledge therefore appears about three cycles after the SCL falling edge, and the busy counter loads three edges after SDA rises during a stop. The bench holds every SCL phase for eight clocks. It samples the acknowledge mid-way through the high phase of the ninth clock, and checks release eight cycles after that clock falls. Busy length and strobes are counted on every falling clock edge, so the expected count of exactly `BUSY_CYCLES` does not depend on when the stop was seen.

// File: rtl/twowire_poll_slave.sv
module twowire_poll_slave #(
  parameter int          BUSY_CYCLES = 500000,
  parameter logic [7:0]  NV_OPCODES  = 8'hC0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] addr_pins,
  output logic       sda_oe,
  output logic       cmd_stb,
  output logic [2:0] opcode_o,
  output logic [1:0] ptr_o,
  output logic       rw_o,
  output logic       busy_o
);
  localparam logic [3:0] DEV_TYPE = 4'b0101;
  localparam int         BW       = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ID, ST_INSTR, ST_SKIP} st_t;

  logic          scl_m, scl_s, scl_d, sda_m, sda_s, sda_d;
  logic [7:0]    sh;
  logic [3:0]    bitcnt;
  logic          ack_ph, rw_q, nv_pend;
  logic [BW-1:0] busy_cnt;
  st_t           st;

  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire id_ok     = (sh[7:4] == DEV_TYPE) && (sh[3:2] == addr_pins) && !busy_o;

  assign busy_o = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_d} <= 3'b111;
      {sda_m, sda_s, sda_d} <= 3'b111;
      sh <= '0; bitcnt <= '0; ack_ph <= 1'b0; rw_q <= 1'b0; nv_pend <= 1'b0;
      busy_cnt <= '0; st <= ST_IDLE; sda_oe <= 1'b0; cmd_stb <= 1'b0;
      opcode_o <= '0; ptr_o <= '0; rw_o <= 1'b0;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_d <= sda_s;
      cmd_stb <= 1'b0;
      if (busy_o) busy_cnt <= busy_cnt - BW'(1);
      if (start_det) begin
        st <= ST_ID; bitcnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0; nv_pend <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; bitcnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0; nv_pend <= 1'b0;
        if (nv_pend) busy_cnt <= BW'(BUSY_CYCLES);
      end else if (st != ST_IDLE) begin
        if (scl_rise && !ack_ph && bitcnt < 4'd8) begin
          sh     <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall) begin
          if (ack_ph) begin
            ack_ph <= 1'b0; sda_oe <= 1'b0; bitcnt <= '0;
            case (st)
              ST_ID:    st <= sda_oe ? ST_INSTR : ST_SKIP;
              ST_INSTR: begin
                st       <= ST_SKIP;
                cmd_stb  <= 1'b1;
                opcode_o <= sh[7:5];
                ptr_o    <= sh[1:0];
                rw_o     <= rw_q;
                nv_pend  <= !rw_q && NV_OPCODES[sh[7:5]];
              end
              default:  st <= ST_SKIP;
            endcase
          end else if (bitcnt == 4'd8) begin
            ack_ph <= 1'b1;
            case (st)
              ST_ID:    begin sda_oe <= id_ok; rw_q <= sh[0]; end
              ST_INSTR: sda_oe <= 1'b1;
              default:  sda_oe <= 1'b0;
            endcase
          end
        end
      end
    end
  end

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ID) && (bitcnt == 4'd0) && !sda_oe);
  assert_ack_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> ack_ph);
  assert_stb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_det));
  assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stop_det) |=> busy_cnt == $past(busy_cnt) - BW'(1));
  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st == ST_ID) |-> !busy_o);
  assert_stop_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == ST_IDLE) && (bitcnt == 4'd0) && !sda_oe);
endmodule

// File: tb/test_twowire_poll_slave.sv
module test_twowire_poll_slave;
  localparam int N = 600;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] pins = 2'b10;
  logic sda_oe, cmd_stb, rw_o, busy_o;
  logic [2:0] opcode_o;
  logic [1:0] ptr_o;
  wire  sda_bus = sda_m & ~sda_oe;

  int vectors = 0, errors = 0, stb_count = 0, busy_cycles = 0;
  logic [2:0] cap_op; logic [1:0] cap_ptr; logic cap_rw;
  bit done = 0;

  always #4 clk = ~clk;

  twowire_poll_slave #(.BUSY_CYCLES(N), .NV_OPCODES(8'hC0)) i_twowire_poll_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .addr_pins(pins),
    .sda_oe(sda_oe), .cmd_stb(cmd_stb), .opcode_o(opcode_o), .ptr_o(ptr_o),
    .rw_o(rw_o), .busy_o(busy_o));

  always @(negedge clk) begin
    if (cmd_stb) begin stb_count++; cap_op = opcode_o; cap_ptr = ptr_o; cap_rw = rw_o; end
    if (busy_o) busy_cycles++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin errors++; $display("FAIL %s: actual %0d expected %0d", tag, act, exp); end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; w(Q); scl = 1'b1; w(Q); scl = 1'b0; w(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q/2);
    ack = sda_oe; w(Q/2); scl = 1'b0; w(Q);
    check(sda_oe == 1'b0, "R3 release after ninth clock", sda_oe, 0);
  endtask

  function automatic bit model_id_ack(input logic [7:0] b, input logic [1:0] p, input bit busy);
    return (b[7:4] == 4'b0101) && (b[3:2] == p) && !busy;
  endfunction

  task automatic command(input logic [7:0] id, input logic [7:0] ins, input string tag);
    bit a; int s0;
    s0 = stb_count;
    bus_start;
    send_byte(id, a);
    check(a == model_id_ack(id, pins, 1'b0), {tag, " id ack"}, a, model_id_ack(id, pins, 1'b0));
    send_byte(ins, a);
    if (model_id_ack(id, pins, 1'b0)) begin
      check(a == 1'b1, "R5 instruction ack", a, 1);
      check(stb_count == s0 + 1, "R5 strobe count", stb_count - s0, 1);
      check(cap_op == ins[7:5], "R5 opcode", cap_op, ins[7:5]);
      check(cap_ptr == ins[1:0], "R5 pointer", cap_ptr, ins[1:0]);
      check(cap_rw == id[0], "R2 direction", cap_rw, id[0]);
    end else begin
      check(a == 1'b0, "R4 later byte not acked", a, 0);
      check(stb_count == s0, "R4 no strobe", stb_count - s0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    bit a; int polls;
    w(5); rst_n = 1'b1; w(5);
    check(sda_oe == 0 && cmd_stb == 0 && busy_o == 0, "R1 reset state",
          {sda_oe, cmd_stb, busy_o}, 0);

    command(8'h58, 8'hA1, "R2 match write");
    bus_stop; w(40);
    check(busy_o == 0, "R9 volatile write no busy", busy_o, 0);

    command(8'h5A, 8'h43, "R2 bit1 ignored");
    bus_stop;
    command(8'h68, 8'h21, "R4 wrong type");
    bus_stop;
    command(8'h54, 8'h21, "R4 wrong address");
    bus_stop;

    command(8'h59, 8'hC2, "R2 match read");
    bus_stop; w(40);
    check(busy_o == 0, "R9 read with nv opcode no busy", busy_o, 0);

    bus_start; send_bits(8'h58, 4); bus_stop;
    check(sda_oe == 0, "R8 abort by stop", sda_oe, 0);
    command(8'h58, 8'h62, "R8 after stop abort");
    bus_stop;

    bus_start; send_bits(8'h00, 5);
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
    command_repeat: begin
      send_byte(8'h58, a);
      check(a == 1'b1, "R8 repeated start new id", a, 1);
      send_byte(8'h20, a);
      bus_stop;
    end

    busy_cycles = 0;
    command(8'h58, 8'hE3, "R6 nv write");
    w(20);
    check(busy_o == 0, "R6 no busy before stop", busy_o, 0);
    bus_stop; w(4);
    check(busy_o == 1, "R6 busy after stop", busy_o, 1);

    bus_start; send_byte(8'h58, a); bus_stop;
    check(a == 1'b0, "R7 no ack while busy", a, 0);
    polls = 1;
    while (!a && polls < 20) begin
      bus_start; send_byte(8'h58, a); bus_stop; polls++;
    end
    check(a == 1'b1, "R7 ack after busy", a, 1);
    check(polls >= 2, "R7 poll count", polls, 2);
    check(busy_cycles == N, "R6 busy length", busy_cycles, N);

    command(8'h58, 8'h41, "R7 normal after write");
    bus_stop;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule